// File: doc/BRIEF.md
# Memory Self-Test Walker

This block is a self-test engine that exercises an external memory through a simple request/response port. Software sets a group of configuration inputs (pattern source, operation, range mode, walking direction, nesting order of the column, bank and row fields, global inversion, halt-on-error and logging mode) and pulses a start input. The engine then visits each location of the selected range. Depending on the operation it writes a generated word, reads a word and compares it against the expected word, or does both in turn.

Miscompares set a sticky fail flag. The engine records them in one of two ways. In address mode it keeps the first five failing locations, each with the expected and received word. In accumulator mode it ORs together every bit position that mismatched. The engine can stop at the first miscompare, and an abort input ends a running test at once. The configuration is captured when the test starts, so changing the inputs during a run has no effect on that run.

Top module: `mbist_ctrl`

## Requirements
- R1: After reset, busy_o, fail_o, mem_req_o, log_cnt_o and acc_o are all zero.
- R2: A start pulse while idle raises busy_o on the next clock edge. busy_o falls after the last location of the range has been handled. With operation code 11 (and also 10), every location gets exactly one write, followed by one read of the same address. A read request is never followed directly by another request. A start pulse while busy is ignored.
- R3: Range code 11 covers every address from 0 to the top. Code 10 covers the locations between lo_addr_i and hi_addr_i, taken in the selected nesting order (the walk position of each bound under that order gives the limits, and the lower position is used as the low end). Codes 00 and 01 visit only lo_addr_i.
- R4: With cfg_desc low, the walk runs from the low end to the high end of the range. With cfg_desc high, it runs from the high end to the low end.
- R5: The physical address is {row, bank, col}, with col in the low bits. The nesting order code gives the field that changes fastest, then the next, then the slowest: 00 row, col, bank; 01 col, row, bank; 10 bank, col, row; 11 col, bank, row.
- R6: Pattern code 10 uses the seed on the first location visited and rotates it left by one bit for each later location. Code 01 alternates the seed and its complement, starting with the seed. Codes 00 and 11 use the seed unchanged.
- R7: cfg_invert complements both the written word and the word expected on read. A seed of 1 with invert set writes a single 0 bit walking through ones, and reading that back gives no miscompare.
- R8: Operation code 00 issues only writes. Code 01 issues only reads and compares each one against the pattern.
- R9: fail_o is set when any read word differs from the expected word. It stays set across later tests and is cleared only by clr_fail_i.
- R10: With cfg_halt set, the engine goes idle right after the first miscompare, and the log holds that failure. Otherwise it continues to the end of the range.
- R11: With cfg_logbits low, the first five miscompares of a test are logged in the order they are detected. Each entry holds the physical address, the expected word and the received word. Entry i sits at field i of the flat log outputs. log_cnt_o stops at five. Starting a test clears the log.
- R12: With cfg_logbits high, acc_o collects the OR of (expected XOR received) over all reads of the test, and log_cnt_o stays zero.
- R13: abort_i while busy returns the engine to idle on the next edge, and no further memory requests are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| abort_i | input | 1 | Abort pulse |
| clr_fail_i | input | 1 | Clear the fail flag |
| cfg_dtype | input | 2 | Pattern source code |
| cfg_cmd | input | 2 | Operation code |
| cfg_atype | input | 2 | Range mode code |
| cfg_desc | input | 1 | Walk from the high end downward |
| cfg_order | input | 2 | Field nesting order code |
| cfg_invert | input | 1 | Complement write and expected data |
| cfg_halt | input | 1 | Stop at first miscompare |
| cfg_logbits | input | 1 | 1: bit accumulator, 0: address log |
| seed_i | input | DATA_W | Pattern seed |
| lo_addr_i | input | ROW_W+BANK_W+COL_W | First bound of the window / single address |
| hi_addr_i | input | ROW_W+BANK_W+COL_W | Second bound of the window |
| busy_o | output | 1 | Test running |
| fail_o | output | 1 | Sticky miscompare flag |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ROW_W+BANK_W+COL_W | Physical address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| log_cnt_o | output | $clog2(LOG_N+1) | Entries held in the address log |
| log_addr_o | output | LOG_N*(ROW_W+BANK_W+COL_W) | Logged addresses, entry i at field i |
| log_exp_o | output | LOG_N*DATA_W | Logged expected words |
| log_got_o | output | LOG_N*DATA_W | Logged received words |
| acc_o | output | DATA_W | Failing-bit accumulator |

## Verification
The bench builds the engine with two row bits, one bank bit, two column bits and 8-bit words. This gives 32 locations, so a full walk can be compared address by address. All four nesting orders give visibly different sequences, and an 8-bit rotation wraps several times within one walk. A memory model that flips chosen bits at every fourth address produces eight failures per walk. That is enough to overflow the five-entry log and to show halting on the second location.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_WAIT,
    ST_ADV
  } mb_state_e;

  // pattern source codes
  localparam logic [1:0] DT_CHECKER = 2'b01;
  localparam logic [1:0] DT_ROTATE  = 2'b10;

  // operation codes
  localparam logic [1:0] OP_WRITE = 2'b00;
  localparam logic [1:0] OP_READ  = 2'b01;

  // range codes
  localparam logic [1:0] RG_WINDOW = 2'b10;
  localparam logic [1:0] RG_FULL   = 2'b11;

  // nesting orders, fastest field named first
  localparam logic [1:0] ORD_ROW  = 2'b00;
  localparam logic [1:0] ORD_COL  = 2'b01;
  localparam logic [1:0] ORD_BANK = 2'b10;
  localparam logic [1:0] ORD_CBR  = 2'b11;

endpackage

// File: rtl/mbist_addr_map.sv
// Converts between the physical address {row, bank, col} and the walk
// position for a given nesting order. TO_PHYS selects the direction.
module mbist_addr_map
  import mbist_pkg::*;
#(
  parameter int ROW_W   = 2,
  parameter int BANK_W  = 1,
  parameter int COL_W   = 2,
  parameter bit TO_PHYS = 1'b1
) (
  input  logic [1:0]                    order,
  input  logic [ROW_W+BANK_W+COL_W-1:0] a_in,
  output logic [ROW_W+BANK_W+COL_W-1:0] a_out
);

  logic [ROW_W-1:0]  row;
  logic [BANK_W-1:0] bank;
  logic [COL_W-1:0]  col;

  generate
    if (TO_PHYS) begin : g_to_phys
      always_comb begin
        case (order)
          ORD_ROW: begin
            row  = a_in[0 +: ROW_W];
            col  = a_in[ROW_W +: COL_W];
            bank = a_in[ROW_W+COL_W +: BANK_W];
          end
          ORD_COL: begin
            col  = a_in[0 +: COL_W];
            row  = a_in[COL_W +: ROW_W];
            bank = a_in[COL_W+ROW_W +: BANK_W];
          end
          ORD_BANK: begin
            bank = a_in[0 +: BANK_W];
            col  = a_in[BANK_W +: COL_W];
            row  = a_in[BANK_W+COL_W +: ROW_W];
          end
          default: begin
            col  = a_in[0 +: COL_W];
            bank = a_in[COL_W +: BANK_W];
            row  = a_in[COL_W+BANK_W +: ROW_W];
          end
        endcase
        a_out = {row, bank, col};
      end
    end else begin : g_to_walk
      always_comb begin
        col  = a_in[0 +: COL_W];
        bank = a_in[COL_W +: BANK_W];
        row  = a_in[COL_W+BANK_W +: ROW_W];
        case (order)
          ORD_ROW:  a_out = {bank, col, row};
          ORD_COL:  a_out = {bank, row, col};
          ORD_BANK: a_out = {row, col, bank};
          default:  a_out = {row, bank, col};
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/mbist_addr_gen.sv
// Walk-position counter with captured bounds, direction and order.
module mbist_addr_gen
  import mbist_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int BANK_W = 1,
  parameter int COL_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic                          step,
  input  logic [1:0]                    atype,
  input  logic                          desc,
  input  logic [1:0]                    order,
  input  logic [ROW_W+BANK_W+COL_W-1:0] lo_addr,
  input  logic [ROW_W+BANK_W+COL_W-1:0] hi_addr,
  output logic [ROW_W+BANK_W+COL_W-1:0] phys,
  output logic                          at_end
);

  localparam int AW = ROW_W + BANK_W + COL_W;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  logic [AW-1:0] lo_walk, hi_walk, win_a, win_b, first_pos, final_pos;
  logic [AW-1:0] cur_q, cur_d, end_q, end_d;
  logic [1:0]    order_q, order_d;
  logic          desc_q, desc_d;

  mbist_addr_map #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .TO_PHYS(1'b0))
    u_lo_map (.order(order), .a_in(lo_addr), .a_out(lo_walk));

  mbist_addr_map #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .TO_PHYS(1'b0))
    u_hi_map (.order(order), .a_in(hi_addr), .a_out(hi_walk));

  mbist_addr_map #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .TO_PHYS(1'b1))
    u_cur_map (.order(order_q), .a_in(cur_q), .a_out(phys));

  // range limits in walk positions
  always_comb begin
    case (atype)
      RG_FULL: begin
        win_a = '0;
        win_b = TOP;
      end
      RG_WINDOW: begin
        win_a = (lo_walk <= hi_walk) ? lo_walk : hi_walk;
        win_b = (lo_walk <= hi_walk) ? hi_walk : lo_walk;
      end
      default: begin
        win_a = lo_walk;
        win_b = lo_walk;
      end
    endcase
    first_pos = desc ? win_b : win_a;
    final_pos = desc ? win_a : win_b;
  end

  assign at_end = (cur_q == end_q);

  always_comb begin
    cur_d   = cur_q;
    end_d   = end_q;
    order_d = order_q;
    desc_d  = desc_q;
    if (load) begin
      cur_d   = first_pos;
      end_d   = final_pos;
      order_d = order;
      desc_d  = desc;
    end else if (step) begin
      cur_d = desc_q ? (cur_q - 1'b1) : (cur_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      end_q   <= '0;
      order_q <= '0;
      desc_q  <= 1'b0;
    end else if (load || step) begin
      cur_q   <= cur_d;
      end_q   <= end_d;
      order_q <= order_d;
      desc_q  <= desc_d;
    end
  end

endmodule

// File: rtl/mbist_pattern.sv
// Data pattern source: solid seed, alternating seed/complement, or
// left-rotating seed, with optional global inversion.
module mbist_pattern
  import mbist_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [1:0]        dtype,
  input  logic              invert,
  input  logic [DATA_W-1:0] seed,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] pat_q, pat_d;
  logic [1:0]        dtype_q, dtype_d;
  logic              inv_q, inv_d;
  logic              odd_q, odd_d;
  logic [DATA_W-1:0] base;

  always_comb begin
    pat_d   = pat_q;
    dtype_d = dtype_q;
    inv_d   = inv_q;
    odd_d   = odd_q;
    if (load) begin
      pat_d   = seed;
      dtype_d = dtype;
      inv_d   = invert;
      odd_d   = 1'b0;
    end else if (adv) begin
      odd_d = ~odd_q;
      if (dtype_q == DT_ROTATE) begin
        pat_d = {pat_q[DATA_W-2:0], pat_q[DATA_W-1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q   <= '0;
      dtype_q <= '0;
      inv_q   <= 1'b0;
      odd_q   <= 1'b0;
    end else if (load || adv) begin
      pat_q   <= pat_d;
      dtype_q <= dtype_d;
      inv_q   <= inv_d;
      odd_q   <= odd_d;
    end
  end

  always_comb begin
    if (dtype_q == DT_CHECKER && odd_q) begin
      base = ~pat_q;
    end else begin
      base = pat_q;
    end
    word = base ^ {DATA_W{inv_q}};
  end

endmodule

// File: rtl/mbist_fail_log.sv
// Failure record: ordered address/data log or failing-bit accumulator.
module mbist_fail_log #(
  parameter int AW     = 5,
  parameter int DATA_W = 8,
  parameter int LOG_N  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    hit,
  input  logic                    mode_bits,
  input  logic [AW-1:0]           addr,
  input  logic [DATA_W-1:0]       exp_word,
  input  logic [DATA_W-1:0]       got_word,
  output logic [$clog2(LOG_N+1)-1:0] cnt,
  output logic [LOG_N*AW-1:0]     addr_flat,
  output logic [LOG_N*DATA_W-1:0] exp_flat,
  output logic [LOG_N*DATA_W-1:0] got_flat,
  output logic [DATA_W-1:0]       acc
);

  localparam int CW = $clog2(LOG_N + 1);
  localparam logic [CW-1:0] FULL = CW'(LOG_N);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              take;

  assign take = hit && !mode_bits && (cnt_q != FULL);

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (clr) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (hit) begin
      if (mode_bits) begin
        acc_d = acc_q | (exp_word ^ got_word);
      end else if (take) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (clr || hit) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  generate
    for (genvar i = 0; i < LOG_N; i++) begin : g_entry
      logic              we;
      logic [AW-1:0]     a_q;
      logic [DATA_W-1:0] e_q, g_q;

      assign we = !clr && take && (cnt_q == CW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          a_q <= '0;
          e_q <= '0;
          g_q <= '0;
        end else if (we) begin
          a_q <= addr;
          e_q <= exp_word;
          g_q <= got_word;
        end
      end

      assign addr_flat[i*AW +: AW]        = a_q;
      assign exp_flat[i*DATA_W +: DATA_W] = e_q;
      assign got_flat[i*DATA_W +: DATA_W] = g_q;
    end
  endgenerate

  assign cnt = cnt_q;
  assign acc = acc_q;

endmodule

// File: rtl/mbist_ctrl.sv
// Self-test walker top: sequencing FSM, compare, sticky fail flag.
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int BANK_W = 1,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8,
  parameter int LOG_N  = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  logic                               abort_i,
  input  logic                               clr_fail_i,
  input  logic [1:0]                         cfg_dtype,
  input  logic [1:0]                         cfg_cmd,
  input  logic [1:0]                         cfg_atype,
  input  logic                               cfg_desc,
  input  logic [1:0]                         cfg_order,
  input  logic                               cfg_invert,
  input  logic                               cfg_halt,
  input  logic                               cfg_logbits,
  input  logic [DATA_W-1:0]                  seed_i,
  input  logic [ROW_W+BANK_W+COL_W-1:0]      lo_addr_i,
  input  logic [ROW_W+BANK_W+COL_W-1:0]      hi_addr_i,
  output logic                               busy_o,
  output logic                               fail_o,
  output logic                               mem_req_o,
  output logic                               mem_we_o,
  output logic [ROW_W+BANK_W+COL_W-1:0]      mem_addr_o,
  output logic [DATA_W-1:0]                  mem_wdata_o,
  input  logic                               mem_rvalid_i,
  input  logic [DATA_W-1:0]                  mem_rdata_i,
  output logic [$clog2(LOG_N+1)-1:0]         log_cnt_o,
  output logic [LOG_N*(ROW_W+BANK_W+COL_W)-1:0] log_addr_o,
  output logic [LOG_N*DATA_W-1:0]            log_exp_o,
  output logic [LOG_N*DATA_W-1:0]            log_got_o,
  output logic [DATA_W-1:0]                  acc_o
);

  localparam int AW = ROW_W + BANK_W + COL_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe[1];

  mb_state_e         state_q, state_d;
  logic [1:0]        cmd_q, cmd_d;
  logic              halt_q, halt_d;
  logic              logbits_q, logbits_d;
  logic              fail_q, fail_d;
  logic              load, step, at_end, miscmp, hit;
  logic [AW-1:0]     cur_phys;
  logic [DATA_W-1:0] pat_word;

  mbist_addr_gen #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load    (load),
    .step    (step),
    .atype   (cfg_atype),
    .desc    (cfg_desc),
    .order   (cfg_order),
    .lo_addr (lo_addr_i),
    .hi_addr (hi_addr_i),
    .phys    (cur_phys),
    .at_end  (at_end)
  );

  mbist_pattern #(.DATA_W(DATA_W)) u_pat (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load   (load),
    .adv    (step),
    .dtype  (cfg_dtype),
    .invert (cfg_invert),
    .seed   (seed_i),
    .word   (pat_word)
  );

  assign miscmp = (state_q == ST_WAIT) && mem_rvalid_i && (mem_rdata_i != pat_word);
  assign hit    = miscmp;

  mbist_fail_log #(.AW(AW), .DATA_W(DATA_W), .LOG_N(LOG_N)) u_log (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr       (load),
    .hit       (hit),
    .mode_bits (logbits_q),
    .addr      (cur_phys),
    .exp_word  (pat_word),
    .got_word  (mem_rdata_i),
    .cnt       (log_cnt_o),
    .addr_flat (log_addr_o),
    .exp_flat  (log_exp_o),
    .got_flat  (log_got_o),
    .acc       (acc_o)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          state_d = (cfg_cmd == OP_READ) ? ST_RD : ST_WR;
        end
      end
      ST_WR:   state_d = (cmd_q == OP_WRITE) ? ST_ADV : ST_RD;
      ST_RD:   state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid_i) begin
          state_d = (miscmp && halt_q) ? ST_IDLE : ST_ADV;
        end
      end
      ST_ADV: begin
        if (at_end) begin
          state_d = ST_IDLE;
        end else begin
          step    = 1'b1;
          state_d = (cmd_q == OP_READ) ? ST_RD : ST_WR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort_i && (state_q != ST_IDLE)) begin
      state_d = ST_IDLE;
      step    = 1'b0;
    end
  end

  always_comb begin
    cmd_d     = load ? cfg_cmd     : cmd_q;
    halt_d    = load ? cfg_halt    : halt_q;
    logbits_d = load ? cfg_logbits : logbits_q;
    fail_d    = fail_q;
    if (clr_fail_i) begin
      fail_d = 1'b0;
    end
    if (miscmp) begin
      fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cmd_q     <= '0;
      halt_q    <= 1'b0;
      logbits_q <= 1'b0;
    end else if (load) begin
      cmd_q     <= cmd_d;
      halt_q    <= halt_d;
      logbits_q <= logbits_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      fail_q <= 1'b0;
    end else if (clr_fail_i || miscmp) begin
      fail_q <= fail_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign fail_o      = fail_q;
  assign mem_req_o   = (state_q == ST_WR) || (state_q == ST_RD);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = cur_phys;
  assign mem_wdata_o = pat_word;

endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk #(
  parameter int CW    = 3,
  parameter int LOG_N = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          abort_i,
  input logic          clr_fail_i,
  input logic          busy_o,
  input logic          fail_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [CW-1:0] log_cnt_o
);

  // R2: requests only while a test runs
  p_req_in_test_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  // R2: a read is followed by a gap while its data returns
  p_read_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);

  // R9: fail flag holds until cleared
  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clr_fail_i) |=> fail_o);

  // R11: log never exceeds its depth
  p_log_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    log_cnt_o <= CW'(LOG_N));

  // R11: a full log stays full until a new test starts
  p_log_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (log_cnt_o == CW'(LOG_N) && !(start_i && !busy_o)) |=> log_cnt_o == CW'(LOG_N));

  // R13: abort ends the test on the next edge
  p_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && abort_i) |=> !busy_o);

endmodule

bind mbist_ctrl mbist_ctrl_chk #(.CW($clog2(LOG_N+1)), .LOG_N(LOG_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .abort_i    (abort_i),
  .clr_fail_i (clr_fail_i),
  .busy_o     (busy_o),
  .fail_o     (fail_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .log_cnt_o  (log_cnt_o)
);

// File: tb/sim_mbist_ctrl.sv
module sim_mbist_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 2, BW = 1, CWD = 2, DW = 8, LN = 5;
  localparam int AW = RW + BW + CWD;
  localparam int NLOC = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, abort_i = 1'b0, clr_fail_i = 1'b0;
  logic [1:0] cfg_dtype = '0, cfg_cmd = '0, cfg_atype = '0, cfg_order = '0;
  logic cfg_desc = 1'b0, cfg_invert = 1'b0, cfg_halt = 1'b0, cfg_logbits = 1'b0;
  logic [DW-1:0] seed_i = '0;
  logic [AW-1:0] lo_addr_i = '0, hi_addr_i = '0;
  logic busy_o, fail_o, mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, acc_o;
  logic mem_rvalid_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [2:0] log_cnt_o;
  logic [LN*AW-1:0] log_addr_o;
  logic [LN*DW-1:0] log_exp_o, log_got_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_ctrl #(.ROW_W(RW), .BANK_W(BW), .COL_W(CWD), .DATA_W(DW), .LOG_N(LN)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .clr_fail_i(clr_fail_i), .cfg_dtype(cfg_dtype), .cfg_cmd(cfg_cmd),
    .cfg_atype(cfg_atype), .cfg_desc(cfg_desc), .cfg_order(cfg_order),
    .cfg_invert(cfg_invert), .cfg_halt(cfg_halt), .cfg_logbits(cfg_logbits),
    .seed_i(seed_i), .lo_addr_i(lo_addr_i), .hi_addr_i(hi_addr_i),
    .busy_o(busy_o), .fail_o(fail_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .log_cnt_o(log_cnt_o), .log_addr_o(log_addr_o), .log_exp_o(log_exp_o),
    .log_got_o(log_got_o), .acc_o(acc_o)
  );

  // memory model with injectable bit flips at addresses where a[1:0]==01
  logic [DW-1:0] mem [NLOC];
  logic          flt_on = 1'b0;
  logic [DW-1:0] flt_mask = '0;
  logic [AW-1:0] wr_a [256];
  logic [DW-1:0] wr_d [256];
  int wr_n = 0;
  int rd_n = 0;

  always @(posedge clk) begin
    mem_rvalid_i <= 1'b0;
    if (mem_req_o) begin
      if (mem_we_o) begin
        mem[mem_addr_o] <= mem_wdata_o;
        wr_a[wr_n % 256] <= mem_addr_o;
        wr_d[wr_n % 256] <= mem_wdata_o;
        wr_n <= wr_n + 1;
      end else begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= mem[mem_addr_o] ^
                        ((flt_on && mem_addr_o[1:0] == 2'b01) ? flt_mask : '0);
        rd_n <= rd_n + 1;
      end
    end
  end

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  // ---- independent reference of the walk ----
  function automatic logic [AW-1:0] w2p(input logic [AW-1:0] w, input int ord);
    logic [1:0] r, c;
    logic b;
    case (ord)
      0: begin r = w[1:0]; c = w[3:2]; b = w[4]; end
      1: begin c = w[1:0]; r = w[3:2]; b = w[4]; end
      2: begin b = w[0]; c = w[2:1]; r = w[4:3]; end
      default: begin c = w[1:0]; b = w[2]; r = w[4:3]; end
    endcase
    return {r, b, c};
  endfunction

  function automatic logic [AW-1:0] p2w(input logic [AW-1:0] p, input int ord);
    for (int w = 0; w < NLOC; w++) begin
      if (w2p(AW'(w), ord) == p) return AW'(w);
    end
    return '0;
  endfunction

  function automatic logic [DW-1:0] xpat(input int dt, input logic [DW-1:0] sd,
                                         input int k, input logic inv);
    logic [DW-1:0] v;
    case (dt)
      2: v = (sd << (k % DW)) | (sd >> ((DW - (k % DW)) % DW));
      1: v = (k % 2 == 1) ? ~sd : sd;
      default: v = sd;
    endcase
    return v ^ {DW{inv}};
  endfunction

  logic [AW-1:0] exp_a [NLOC];
  int exp_n;

  task automatic build_exp();
    int a, b, la, lb;
    la = int'(p2w(lo_addr_i, int'(cfg_order)));
    lb = int'(p2w(hi_addr_i, int'(cfg_order)));
    if (cfg_atype == 2'b11) begin a = 0; b = NLOC - 1; end
    else if (cfg_atype == 2'b10) begin a = (la < lb) ? la : lb; b = (la < lb) ? lb : la; end
    else begin a = la; b = la; end
    exp_n = b - a + 1;
    for (int k = 0; k < exp_n; k++) begin
      exp_a[k] = w2p(AW'(cfg_desc ? b - k : a + k), int'(cfg_order));
    end
  endtask

  task automatic setup(input logic [1:0] dt, input logic [1:0] cm, input logic [1:0] at,
                       input logic ds, input logic [1:0] od, input logic inv,
                       input logic hl, input logic lb, input logic [DW-1:0] sd,
                       input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    @(negedge clk);
    cfg_dtype = dt; cfg_cmd = cm; cfg_atype = at; cfg_desc = ds; cfg_order = od;
    cfg_invert = inv; cfg_halt = hl; cfg_logbits = lb; seed_i = sd;
    lo_addr_i = lo; hi_addr_i = hi;
  endtask

  int base_wr, base_rd;

  task automatic go();
    base_wr = wr_n;
    base_rd = rd_n;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
  endtask

  task automatic clear_fail();
    @(negedge clk);
    clr_fail_i = 1'b1;
    @(negedge clk);
    clr_fail_i = 1'b0;
  endtask

  // check written sequence against the reference
  task automatic check_writes(input string rq);
    check({rq, " write count"}, 64'(wr_n - base_wr), 64'(exp_n));
    for (int k = 0; k < exp_n; k++) begin
      check({rq, " addr"}, 64'(wr_a[(base_wr + k) % 256]), 64'(exp_a[k]));
      check({rq, " data"}, 64'(wr_d[(base_wr + k) % 256]),
            64'(xpat(int'(cfg_dtype), seed_i, k, cfg_invert)));
    end
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    check("R1 busy", 64'(busy_o), 0);
    check("R1 fail", 64'(fail_o), 0);
    check("R1 req", 64'(mem_req_o), 0);
    check("R1 log_cnt", 64'(log_cnt_o), 0);
    check("R1 acc", 64'(acc_o), 0);
  endtask

  task automatic t_walk_zero();
    setup(2'b10, 2'b11, 2'b11, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 8'h01, '0, '0);
    build_exp();
    @(negedge clk);
    start_i = 1'b1;
    base_wr = wr_n; base_rd = rd_n;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", 64'(busy_o), 1);
    while (busy_o) @(negedge clk);
    check_writes("R2 R6 R7 walking zero");
    check("R2 read count", 64'(rd_n - base_rd), 64'(NLOC));
    check("R7 no miscompare", 64'(fail_o), 0);
    check("R7 stored word at 5", 64'(mem[5]), 64'h DF);
  endtask

  task automatic t_orders();
    for (int od = 0; od < 3; od++) begin
      setup(2'b00, 2'b00, 2'b11, 1'b0, 2'(od), 1'b0, 1'b0, 1'b0, 8'hA5, '0, '0);
      build_exp();
      go();
      check_writes("R5 nesting order");
      check("R8 write-only issues no reads", 64'(rd_n - base_rd), 0);
    end
  endtask

  task automatic t_range();
    setup(2'b01, 2'b00, 2'b10, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'h3C, 5'd5, 5'd20);
    build_exp();
    go();
    check("R3 R4 first addr high end", 64'(wr_a[base_wr % 256]), 20);
    check_writes("R3 R4 R6 window descending");
    setup(2'b10, 2'b00, 2'b10, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 8'h81, 5'd22, 5'd6);
    build_exp();
    go();
    check_writes("R3 R5 window in row-fast order");
    setup(2'b00, 2'b00, 2'b00, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'h77, 5'd9, 5'd30);
    build_exp();
    go();
    check_writes("R3 single location");
  endtask

  task automatic t_readonly();
    setup(2'b10, 2'b00, 2'b11, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'h11, '0, '0);
    go();
    setup(2'b10, 2'b01, 2'b11, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'h11, '0, '0);
    go();
    check("R8 read-only writes", 64'(wr_n - base_wr), 0);
    check("R8 read-only reads", 64'(rd_n - base_rd), 64'(NLOC));
    check("R8 read-only matching", 64'(fail_o), 0);
    setup(2'b10, 2'b01, 2'b11, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'h12, '0, '0);
    go();
    check("R8 read-only compares", 64'(fail_o), 1);
    clear_fail();
  endtask

  task automatic t_addr_log();
    flt_on = 1'b1; flt_mask = 8'h81;
    setup(2'b10, 2'b11, 2'b11, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'h01, '0, '0);
    go();
    check("R9 fail set", 64'(fail_o), 1);
    check("R11 log count saturates", 64'(log_cnt_o), 5);
    for (int i = 0; i < LN; i++) begin
      logic [AW-1:0] ea;
      logic [DW-1:0] ex;
      ea = AW'(1 + 4 * i);
      ex = xpat(2, 8'h01, int'(ea), 1'b0);
      check("R11 log addr", 64'(log_addr_o[i*AW +: AW]), 64'(ea));
      check("R11 log expected", 64'(log_exp_o[i*DW +: DW]), 64'(ex));
      check("R11 log received", 64'(log_got_o[i*DW +: DW]), 64'(ex ^ 8'h81));
    end
    flt_on = 1'b0;
    go();
    check("R9 fail sticky over clean test", 64'(fail_o), 1);
    check("R11 log cleared at start", 64'(log_cnt_o), 0);
    clear_fail();
    check("R9 fail cleared", 64'(fail_o), 0);
  endtask

  task automatic t_acc();
    flt_on = 1'b1; flt_mask = 8'h30;
    setup(2'b00, 2'b11, 2'b11, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 8'h5A, '0, '0);
    go();
    check("R12 accumulator", 64'(acc_o), 64'h30);
    check("R12 no address log", 64'(log_cnt_o), 0);
    check("R12 fail", 64'(fail_o), 1);
    flt_on = 1'b0;
    clear_fail();
  endtask

  task automatic t_halt();
    flt_on = 1'b1; flt_mask = 8'h04;
    setup(2'b10, 2'b11, 2'b11, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 8'h01, '0, '0);
    go();
    check("R10 halted busy", 64'(busy_o), 0);
    check("R10 writes before halt", 64'(wr_n - base_wr), 2);
    check("R10 log count", 64'(log_cnt_o), 1);
    check("R10 log addr", 64'(log_addr_o[0 +: AW]), 1);
    flt_on = 1'b0;
    clear_fail();
  endtask

  task automatic t_abort();
    int w0;
    setup(2'b00, 2'b11, 2'b11, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'hC3, '0, '0);
    base_wr = wr_n;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    check("R13 idle after abort", 64'(busy_o), 0);
    w0 = wr_n;
    repeat (10) @(negedge clk);
    check("R13 no requests after abort", 64'(wr_n), 64'(w0));
    check("R13 stopped early", 64'(wr_n - base_wr < NLOC), 1);
  endtask

  task automatic t_start_ignored();
    setup(2'b00, 2'b00, 2'b11, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 8'h0F, '0, '0);
    base_wr = wr_n;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    check("R2 start while busy ignored", 64'(wr_n - base_wr), 64'(NLOC));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_walk_zero();
    t_orders();
    t_range();
    t_readonly();
    t_addr_log();
    t_acc();
    t_halt();
    t_abort();
    t_start_ignored();
    report();
    $finish;
  end

endmodule